// File: doc/BRIEF.md
# Activate Rate Window Limiter

This block sits in a DRAM controller between the command scheduler and the command output. It caps the rate of row activates: no window of `win_len` consecutive controller cycles may contain more than four issued activates. The scheduler presents a request on `act_req` and looks at `act_ok` in the same cycle. An activate counts as issued in any cycle where both are high.

A blocked request is not dropped. The scheduler keeps `act_req` high, and `act_ok` rises on the first cycle the oldest of the last four issued activates leaves the window. Timestamps come from a free-running cycle counter one bit wider than the window length. Ages are computed by modular subtraction, and entries are retired as soon as they expire, so counter wraparound never revives a stale entry.

A window length of zero turns the limiter off. So does any length up to four times the two-cycle bus busy time: at that length the bus occupancy alone keeps the rate legal, and the block never stalls. `act_count` reports how many issued activates are still inside the window.

Top module: `act_window_limiter`

## Requirements
- R1: Out of reset, `act_ok` is 1 and `act_count` is 0.
- R2: With `win_len` above 8, once four activates are live in the window, `act_count` reads 4 and `act_ok` is 0.
- R3: With `win_len` = W above 8 and `act_req` held high from the start, the fifth activate is granted exactly W cycles after the first.
- R4: An activate issued in cycle t is counted in `act_count` during cycles t+1 through t+W-1 and is gone in cycle t+W.
- R5: With `win_len` = 0, `act_ok` is always 1 and `act_count` is always 0.
- R6: With `win_len` from 1 to 8, held requests are granted every cycle, so the fifth grant comes four cycles after the first.
- R7: A request made while `act_ok` is 0 is not recorded and does not lengthen any later block.
- R8: Grant timing stays exact across wraparound of the internal timestamp counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Scheduler wants to issue a row activate this cycle |
| win_len | input | WIN_W | Sliding window length in controller cycles; 0 disables |
| act_ok | output | 1 | Activate may issue this cycle |
| act_count | output | 3 | Issued activates still inside the window |

## Verification
The embedded assertions check, on every cycle:
- a zero window reports an empty count;
- with a steady window length, the count moves by at most one per cycle;
- a blocked request never raises the count;
- an issued activate shows up in the count on the next cycle.

Only the bench scenarios can show the exact cycle of the fifth grant for each window length, the bypass for short windows, the non-recording of blocked requests, and correct timing after the timestamp counter wraps.

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int WIN_W    = 8,
  parameter int MAX_ACTS = 4,
  parameter int BUS_BUSY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_req,
  input  logic [WIN_W-1:0] win_len,
  output logic             act_ok,
  output logic [2:0]       act_count
);
  localparam int TS_W       = WIN_W + 1;
  localparam int PTR_W      = (MAX_ACTS > 1) ? $clog2(MAX_ACTS) : 1;
  localparam int FREE_LIMIT = MAX_ACTS * BUS_BUSY;

  logic [TS_W-1:0]     now_q;
  logic [TS_W-1:0]     ts_q [MAX_ACTS];
  logic [MAX_ACTS-1:0] vld_q;
  logic [MAX_ACTS-1:0] live;
  logic [PTR_W-1:0]    wr_ptr_q;
  logic                bypass, issue;

  genvar g;
  generate
    for (g = 0; g < MAX_ACTS; g++) begin : g_slot
      logic [TS_W-1:0] age;
      assign age     = now_q - ts_q[g];
      assign live[g] = vld_q[g] && (age < {1'b0, win_len});
    end
  endgenerate

  always_comb begin
    act_count = '0;
    for (int i = 0; i < MAX_ACTS; i++) act_count = act_count + {2'b00, live[i]};
  end

  assign bypass = (win_len <= WIN_W'(FREE_LIMIT));
  assign act_ok = bypass || (act_count < 3'(MAX_ACTS));
  assign issue  = act_req && act_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q    <= '0;
      vld_q    <= '0;
      wr_ptr_q <= '0;
      for (int i = 0; i < MAX_ACTS; i++) ts_q[i] <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      vld_q <= live;
      if (issue) begin
        ts_q[wr_ptr_q]  <= now_q;
        vld_q[wr_ptr_q] <= 1'b1;
        wr_ptr_q        <= (wr_ptr_q == PTR_W'(MAX_ACTS - 1)) ? '0 : wr_ptr_q + 1'b1;
      end
    end
  end

  // R5
  off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len == '0) |-> (act_count == 3'd0 && act_ok));

  // R4
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(win_len) |-> ({1'b0, act_count} <= {1'b0, $past(act_count)} + 4'd1) &&
                         ({1'b0, act_count} + 4'd1 >= {1'b0, $past(act_count)}));

  // R7
  blocked_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && !act_ok) |=> (act_count <= $past(act_count)) || !$stable(win_len));

  // R4
  issue_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && act_ok && win_len > WIN_W'(1)) |=> (act_count != 3'd0) || !$stable(win_len));
endmodule

// File: tb/act_window_limiter_tb.sv
`timescale 1ns/1ps
module act_window_limiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_req = 1'b0;
  logic [7:0] win_len = 8'd0;
  logic       act_ok;
  logic [2:0] act_count;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  act_window_limiter u_dut (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .win_len(win_len),
    .act_ok(act_ok), .act_count(act_count)
  );

  // {window length, expected cycles from first to fifth grant}
  localparam logic [15:0] VEC [7] = '{
    {8'd0,   8'd4},   {8'd3,   8'd4},   {8'd8,   8'd4},
    {8'd9,   8'd9},   {8'd20,  8'd20},  {8'd100, 8'd100},
    {8'd255, 8'd255}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; act_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic burst(input int w, input int exp5, input string req);
    int c = 0, grants = 0, first = -1, fifth = -1;
    bit blocked = 1'b0, cnt_full = 1'b0, off_bad = 1'b0;
    win_len = 8'(w);
    act_req = 1'b1;
    while (grants < 5 && c < 600) begin
      #1;
      if (w == 0 && act_count != 3'd0) off_bad = 1'b1;
      if (act_ok) begin
        if (grants == 0) first = c;
        grants++;
        if (grants == 5) fifth = c;
      end else if (grants == 4) begin
        blocked = 1'b1;
        if (act_count == 3'd4) cnt_full = 1'b1;
      end
      c++;
      @(negedge clk);
    end
    act_req = 1'b0;
    check(req, fifth - first, exp5);
    check((w > 8) ? "R2" : "R6", int'(blocked && cnt_full), int'(w > 8));
    if (w == 0) check("R5", int'(off_bad), 0);
  endtask

  initial begin
    do_reset();
    #1;
    check("R1 ok", int'(act_ok), 1);
    check("R1 count", int'(act_count), 0);
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      do_reset();
      burst(int'(VEC[v][15:8]), int'(VEC[v][7:0]),
            (VEC[v][15:8] > 8'd8) ? "R3" : "R6");
    end

    // R4: single activate ages out after exactly W cycles
    do_reset();
    win_len = 8'd20;
    act_req = 1'b1;
    @(negedge clk);
    act_req = 1'b0;
    #1 check("R4 t+1", int'(act_count), 1);
    repeat (18) @(negedge clk);
    #1 check("R4 t+19", int'(act_count), 1);
    @(negedge clk);
    #1 check("R4 t+20", int'(act_count), 0);

    // R7: requests while blocked are not recorded
    do_reset();
    win_len = 8'd20;
    act_req = 1'b1;
    repeat (14) @(negedge clk);
    act_req = 1'b0;
    #1 check("R7 held", int'(act_count), 4);
    repeat (6) @(negedge clk);
    #1 check("R7 t+20", int'(act_count), 3);
    repeat (4) @(negedge clk);
    #1 check("R7 t+24", int'(act_count), 0);
    check("R7 ok", int'(act_ok), 1);

    // R8: burst straddling timestamp counter wrap
    do_reset();
    win_len = 8'd200;
    repeat (430) @(negedge clk);
    burst(200, 200, "R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule